// File: doc/BRIEF.md
# Two-Wire EEPROM Address-Phase Decoder

This block sits behind the bit-level shifter of a two-wire serial EEPROM slave. It works on whole bytes. The shifter tells it about start conditions (including repeated starts), stop conditions, each received byte, and the master's acknowledge or not-acknowledge after a byte the slave has sent. The decoder checks the first byte after a start, the device byte, and answers ACK or NACK for every byte of an active transfer. It then works out which target the transfer addresses and reports the result to the storage and data-phase logic that follows.

The upper nibble of the device byte chooses between the main memory array and an auxiliary space. Inside the auxiliary space, the high bits of the word byte choose the security register, the security lock command or the write-protection register. The device byte also carries the array address bits above bit 7: one bit when `ADDR_W` = 9, two bits when `ADDR_W` = 10. The hardware-address bits that are not used for addressing are compared with the preset value `HW_ADDR`. A read that comes straight after a start has no word byte. It continues from the low byte of the last word address that was decoded.

Every output is registered. A byte that is sampled on clock edge N has its response on the outputs after edge N.

Top module: `eeaddr_decoder`

## Requirements
- R1: In a device byte, bits 7:4 = 4'b1010 select the main array and 4'b1011 select the auxiliary space. Any other value is answered with `ack_valid`=1 and `ack`=0.
- R2: With `ADDR_W`=9, device byte bits 3:2 must equal `HW_ADDR[1:0]`. With `ADDR_W`=10, only bit 3 is compared, against `HW_ADDR[1]`. A mismatch is answered with NACK.
- R3: With `ADDR_W`=9, device bit 1 becomes `addr[8]`. With `ADDR_W`=10, device bits 2:1 become `addr[9:8]`.
- R4: After a NACK, every byte gets no response (`ack_valid` stays 0) until the next start.
- R5: For a write (device bit 0 = 0), the device byte is ACKed without a strobe. The next byte is the word byte. It is ACKed and, in the same cycle, `addr_valid` pulses for one cycle with `rw`=0 and `addr[7:0]` equal to the word byte.
- R6: For a read (device bit 0 = 1), `addr_valid` pulses together with the ACK of the device byte, with `rw`=1. `addr[7:0]` holds the last accepted word byte (0 after reset).
- R7: In the auxiliary space, word bits 7:6 = 2'b10 give `region`=1 (security register, offset in bits 4:0). Bits 7:6 = 2'b11 give `region`=3 (write protection). Bits 7:4 = 4'b0110 give `region`=2 (lock). Any other word byte is NACKed, and R4 then applies. The main array reports `region`=0.
- R8: An auxiliary device byte is NACKed while a main-array transfer is still open. A transfer opens when a main-array device byte is ACKed. It closes only on a stop or a master NACK; a repeated start does not close it.
- R9: A write aimed at the read-only lower 16 bytes of the security register is still ACKed on both the device byte and the word byte.
- R10: A start in any state, including a repeated start in the middle of a transfer, makes the next byte a device byte.
- R11: After reset, `ack_valid`, `ack`, `addr_valid`, `region`, `addr` and `rw` are all 0.
- R12: Once the address phase is complete, each further byte gets `ack_valid`=1 and `ack`=1 with no `addr_valid`. `ack_valid` is never raised without a byte in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_seen | input | 1 | One-cycle pulse on a start or repeated start |
| stop_seen | input | 1 | One-cycle pulse on a stop |
| byte_valid | input | 1 | One-cycle pulse when a received byte is on `byte_data` |
| byte_data | input | 8 | Received byte |
| mack_valid | input | 1 | Master acknowledge slot after a slave-sent byte |
| mack_nack | input | 1 | 1 when the master answered NACK in that slot |
| ack_valid | output | 1 | A response to the previous byte is present |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| addr_valid | output | 1 | One-cycle strobe when the address phase completes |
| region | output | 2 | 0 array, 1 security register, 2 lock, 3 write protection |
| addr | output | ADDR_W | Decoded address |
| rw | output | 1 | 1 = read, 0 = write |

## Verification
The properties assume the shifter behaves: start, stop, master NACK and a byte never arrive in the same cycle, and at least one idle cycle separates events. They also assume a strobe cannot follow another strobe directly, because a start always sits between two address phases. The bench meets these assumptions by driving one event per task on the falling edge and clearing it one period later. It applies identical traffic to a 9-bit and a 10-bit instance, whose hardware-address rules differ, so the expected responses are computed separately for each.

// File: rtl/eeaddr_pkg.sv
package eeaddr_pkg;

  typedef enum logic [1:0] {
    RG_ARRAY  = 2'd0,
    RG_SECURE = 2'd1,
    RG_LOCK   = 2'd2,
    RG_WPROT  = 2'd3
  } region_e;

  localparam logic [3:0] TYPE_ARRAY = 4'hA;
  localparam logic [3:0] TYPE_AUX   = 4'hB;

  typedef struct packed {
    logic    ok;
    region_e rg;
  } wdec_t;

  // Auxiliary-space word decode; priority: 10xx, 11xx, then 0110.
  function automatic wdec_t aux_word_decode(input logic [3:0] hi);
    wdec_t d;
    d.ok = 1'b1;
    d.rg = RG_SECURE;
    if (hi[3:2] == 2'b10)      d.rg = RG_SECURE;
    else if (hi[3:2] == 2'b11) d.rg = RG_WPROT;
    else if (hi == 4'b0110)    d.rg = RG_LOCK;
    else                       d.ok = 1'b0;
    return d;
  endfunction

endpackage

// File: rtl/eeaddr_devchk.sv
module eeaddr_devchk #(
  parameter int          ADDR_W  = 9,
  parameter logic [1:0]  HW_ADDR = 2'b00,
  localparam int         MSB_W   = ADDR_W - 8
) (
  input  logic [7:1]       dev_hi,
  output logic             is_array,
  output logic             is_aux,
  output logic             hw_hit,
  output logic [MSB_W-1:0] msbs
);
  import eeaddr_pkg::*;

  assign is_array = (dev_hi[7:4] == TYPE_ARRAY);
  assign is_aux   = (dev_hi[7:4] == TYPE_AUX);

  generate
    if (ADDR_W == 9) begin : g_small
      assign hw_hit = (dev_hi[3:2] == HW_ADDR);
      assign msbs   = dev_hi[1];
    end else begin : g_large
      assign hw_hit = (dev_hi[3] == HW_ADDR[1]);
      assign msbs   = dev_hi[2:1];
    end
  endgenerate

endmodule

// File: rtl/eeaddr_wdec.sv
module eeaddr_wdec (
  input  logic [3:0] word_hi,
  output logic       ok,
  output logic [1:0] region
);
  import eeaddr_pkg::*;

  wdec_t d;
  assign d      = aux_word_decode(word_hi);
  assign ok     = d.ok;
  assign region = d.rg;

endmodule

// File: rtl/eeaddr_term.sv
module eeaddr_term (
  input  logic clk,
  input  logic rst_n,
  input  logic open_evt,
  input  logic close_evt,
  output logic arr_open
);
  always_ff @(posedge clk) begin
    if (!rst_n)         arr_open <= 1'b0;
    else if (close_evt) arr_open <= 1'b0;
    else if (open_evt)  arr_open <= 1'b1;
  end
endmodule

// File: rtl/eeaddr_decoder.sv
module eeaddr_decoder
  import eeaddr_pkg::*;
#(
  parameter int         ADDR_W  = 9,
  parameter logic [1:0] HW_ADDR = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_seen,
  input  logic              stop_seen,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              mack_valid,
  input  logic              mack_nack,
  output logic              ack_valid,
  output logic              ack,
  output logic              addr_valid,
  output logic [1:0]        region,
  output logic [ADDR_W-1:0] addr,
  output logic              rw
);
  localparam int MSB_W = ADDR_W - 8;

  typedef enum logic [1:0] {ST_IDLE, ST_DEV, ST_WORD, ST_DATA} st_e;
  st_e st;

  logic             is_array, is_aux, hw_hit;
  logic [MSB_W-1:0] msbs, msb_q;
  logic             aux_q;
  logic [7:0]       cur_low;
  logic             wd_ok;
  logic [1:0]       wd_rg;
  logic             arr_open;

  // Named events, also observed by the bound checker
  wire master_end    = mack_valid & mack_nack;
  wire byte_go       = byte_valid & ~start_seen & ~stop_seen & ~master_end;
  wire dev_evt       = byte_go & (st == ST_DEV);
  wire word_evt      = byte_go & (st == ST_WORD);
  wire sec_block_evt = dev_evt & is_aux & hw_hit & arr_open;
  wire dev_accept    = dev_evt & hw_hit & (is_array | (is_aux & ~arr_open));
  wire dev_nack_evt  = dev_evt & ~dev_accept;
  wire word_accept   = word_evt & (~aux_q | wd_ok);
  wire st_idle       = (st == ST_IDLE);
  wire open_evt      = dev_accept & is_array;
  wire close_evt     = stop_seen | master_end;

  eeaddr_devchk #(.ADDR_W(ADDR_W), .HW_ADDR(HW_ADDR)) u_devchk (
    .dev_hi   (byte_data[7:1]),
    .is_array (is_array),
    .is_aux   (is_aux),
    .hw_hit   (hw_hit),
    .msbs     (msbs)
  );

  eeaddr_wdec u_wdec (
    .word_hi (byte_data[7:4]),
    .ok      (wd_ok),
    .region  (wd_rg)
  );

  eeaddr_term u_term (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_evt  (open_evt),
    .close_evt (close_evt),
    .arr_open  (arr_open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      ack_valid  <= 1'b0;
      ack        <= 1'b0;
      addr_valid <= 1'b0;
      region     <= RG_ARRAY;
      addr       <= '0;
      rw         <= 1'b0;
      msb_q      <= '0;
      aux_q      <= 1'b0;
      cur_low    <= 8'h00;
    end else begin
      ack_valid  <= 1'b0;
      addr_valid <= 1'b0;
      if (start_seen) begin
        st <= ST_DEV;
      end else if (stop_seen || master_end) begin
        st <= ST_IDLE;
      end else if (byte_valid) begin
        unique case (st)
          ST_DEV: begin
            ack_valid <= 1'b1;
            ack       <= dev_accept;
            if (dev_accept) begin
              rw    <= byte_data[0];
              msb_q <= msbs;
              aux_q <= is_aux;
              if (byte_data[0]) begin
                addr_valid <= 1'b1;
                region     <= is_aux ? RG_SECURE : RG_ARRAY;
                addr       <= {msbs, cur_low};
                st         <= ST_DATA;
              end else begin
                st <= ST_WORD;
              end
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_WORD: begin
            ack_valid <= 1'b1;
            ack       <= word_accept;
            if (word_accept) begin
              addr_valid <= 1'b1;
              region     <= aux_q ? wd_rg : RG_ARRAY;
              addr       <= {msb_q, byte_data};
              cur_low    <= byte_data;
              st         <= ST_DATA;
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_DATA: begin
            ack_valid <= 1'b1;
            ack       <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/eeaddr_decoder_chk.sv
module eeaddr_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_valid,
  input logic stop_seen,
  input logic ack_valid,
  input logic ack,
  input logic addr_valid,
  input logic byte_go,
  input logic st_idle,
  input logic arr_open,
  input logic sec_block_evt,
  input logic dev_nack_evt
);
  // R12: a response only follows a byte
  p_ack_after_byte_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(byte_valid));

  // R4: silence while ignoring the bus
  p_idle_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && byte_go) |=> !ack_valid);

  // R4: a rejected device byte leaves the decoder ignoring the bus
  p_nack_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dev_nack_evt |=> st_idle);

  // R1: a rejected device byte is answered with NACK
  p_nack_on_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dev_nack_evt |=> (ack_valid && !ack));

  // R8: auxiliary access while the array transfer is open is refused
  p_block_aux_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_block_evt |=> (ack_valid && !ack && !addr_valid));

  // R8: a stop closes the array transfer
  p_stop_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !arr_open);

  // R5: the strobe always comes with an ACK
  p_strobe_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (ack_valid && ack));

  // R5: the strobe lasts one cycle
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> !addr_valid);
endmodule

bind eeaddr_decoder eeaddr_decoder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .byte_valid    (byte_valid),
  .stop_seen     (stop_seen),
  .ack_valid     (ack_valid),
  .ack           (ack),
  .addr_valid    (addr_valid),
  .byte_go       (byte_go),
  .st_idle       (st_idle),
  .arr_open      (arr_open),
  .sec_block_evt (sec_block_evt),
  .dev_nack_evt  (dev_nack_evt)
);

// File: tb/eeaddr_decoder_tb.sv
module eeaddr_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_seen = 1'b0, stop_seen = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic mack_valid = 1'b0, mack_nack = 1'b0;

  logic a_av, a_ak, a_sv, a_rw;
  logic [1:0] a_rg;
  logic [8:0] a_ad;
  logic b_av, b_ak, b_sv, b_rw;
  logic [1:0] b_rg;
  logic [9:0] b_ad;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  // 9-bit variant, preset bits 3:2 = 2'b10
  eeaddr_decoder #(.ADDR_W(9), .HW_ADDR(2'b10)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_seen(start_seen), .stop_seen(stop_seen),
    .byte_valid(byte_valid), .byte_data(byte_data), .mack_valid(mack_valid),
    .mack_nack(mack_nack), .ack_valid(a_av), .ack(a_ak), .addr_valid(a_sv),
    .region(a_rg), .addr(a_ad), .rw(a_rw));

  // 10-bit variant, preset bit 3 = 1
  eeaddr_decoder #(.ADDR_W(10), .HW_ADDR(2'b10)) u_dut10 (
    .clk(clk), .rst_n(rst_n), .start_seen(start_seen), .stop_seen(stop_seen),
    .byte_valid(byte_valid), .byte_data(byte_data), .mack_valid(mack_valid),
    .mack_nack(mack_nack), .ack_valid(b_av), .ack(b_ak), .addr_valid(b_sv),
    .region(b_rg), .addr(b_ad), .rw(b_rw));

  task automatic ck(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_seen = 1'b1;
    @(negedge clk) start_seen = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_seen = 1'b1;
    @(negedge clk) stop_seen = 1'b0;
  endtask

  task automatic do_mnack();
    @(negedge clk) begin mack_valid = 1'b1; mack_nack = 1'b1; end
    @(negedge clk) begin mack_valid = 1'b0; mack_nack = 1'b0; end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) begin byte_valid = 1'b1; byte_data = b; end
    @(negedge clk) byte_valid = 1'b0;
  endtask

  task automatic exp_a(input string rq, input logic av, input logic ak, input logic sv);
    ck(rq, "w9 ack_valid", a_av, av);
    if (av) ck(rq, "w9 ack", a_ak, ak);
    ck(rq, "w9 addr_valid", a_sv, sv);
  endtask

  task automatic exp_b(input string rq, input logic av, input logic ak, input logic sv);
    ck(rq, "w10 ack_valid", b_av, av);
    if (av) ck(rq, "w10 ack", b_ak, ak);
    ck(rq, "w10 addr_valid", b_sv, sv);
  endtask

  task automatic exp_both(input string rq, input logic av, input logic ak, input logic sv);
    exp_a(rq, av, ak, sv);
    exp_b(rq, av, ak, sv);
  endtask

  task automatic exp_tgt(input string rq, input logic [1:0] rg, input logic [9:0] ad, input logic w);
    ck(rq, "w9 region", a_rg, rg);
    ck(rq, "w9 addr", a_ad, ad[8:0]);
    ck(rq, "w9 rw", a_rw, w);
    ck(rq, "w10 region", b_rg, rg);
    ck(rq, "w10 addr", b_ad, ad);
    ck(rq, "w10 rw", b_rw, w);
  endtask

  task automatic t_reset();
    exp_both("R11", 1'b0, 1'b0, 1'b0);
    exp_tgt("R11", 2'd0, 10'h000, 1'b0);
  endtask

  task automatic t_array_write();
    do_start();
    send(8'hAA);                      // R1 R2 R3: type A, bits3:1=101
    exp_both("R1", 1'b1, 1'b1, 1'b0);
    send(8'h5C);
    exp_both("R5", 1'b1, 1'b1, 1'b1);
    exp_tgt("R3", 2'd0, 10'h15C, 1'b0);
    send(8'h11);
    exp_both("R12", 1'b1, 1'b1, 1'b0);
    do_stop();
  endtask

  task automatic t_bad_type();
    for (int t = 0; t < 16; t++) begin
      if (t != 10 && t != 11) begin
        do_start();
        send({t[3:0], 4'b1010});
        exp_both("R1", 1'b1, 1'b0, 1'b0);
        send(8'h00);
        exp_both("R4", 1'b0, 1'b0, 1'b0);
        do_stop();
      end
    end
  endtask

  task automatic t_hw_match();
    do_start();
    send(8'hAE);                      // bits3:1=111
    exp_a("R2", 1'b1, 1'b0, 1'b0);
    exp_b("R2", 1'b1, 1'b1, 1'b0);
    send(8'h01);
    exp_a("R4", 1'b0, 1'b0, 1'b0);
    exp_b("R3", 1'b1, 1'b1, 1'b1);
    ck("R3", "w10 addr", b_ad, 10'h301);
    do_stop();
    do_start();
    send(8'hA2);                      // bits3:1=001
    exp_both("R2", 1'b1, 1'b0, 1'b0);
    do_stop();
    do_start();
    send(8'hA6);                      // bits3:1=011
    exp_both("R2", 1'b1, 1'b0, 1'b0);
    do_stop();
    do_start();
    send(8'hA8);                      // bits3:1=100
    exp_both("R2", 1'b1, 1'b1, 1'b0);
    send(8'h00);
    exp_both("R5", 1'b1, 1'b1, 1'b1);
    exp_tgt("R3", 2'd0, 10'h000, 1'b0);
    do_stop();
  endtask

  task automatic t_current_read();
    do_start();
    send(8'hAA);
    send(8'h5C);
    do_stop();
    do_start();
    send(8'hAB);
    exp_both("R6", 1'b1, 1'b1, 1'b1);
    exp_tgt("R6", 2'd0, 10'h15C, 1'b1);
    do_mnack();
  endtask

  task automatic t_restart_read();
    do_start();
    send(8'hA8);
    send(8'h33);
    exp_both("R5", 1'b1, 1'b1, 1'b1);
    do_start();                       // repeated start
    send(8'hA9);
    exp_both("R10", 1'b1, 1'b1, 1'b1);
    exp_tgt("R10", 2'd0, 10'h033, 1'b1);
    do_mnack();
  endtask

  task automatic t_aux_decode();
    do_stop();
    do_start();
    send(8'hB8);
    exp_both("R9", 1'b1, 1'b1, 1'b0);
    send(8'h85);                      // read-only lower half
    exp_both("R9", 1'b1, 1'b1, 1'b1);
    exp_tgt("R7", 2'd1, 10'h085, 1'b0);
    do_stop();
    do_start();
    send(8'hB8);
    send(8'h60);
    exp_both("R7", 1'b1, 1'b1, 1'b1);
    exp_tgt("R7", 2'd2, 10'h060, 1'b0);
    do_stop();
    do_start();
    send(8'hB8);
    send(8'hC0);
    exp_both("R7", 1'b1, 1'b1, 1'b1);
    exp_tgt("R7", 2'd3, 10'h0C0, 1'b0);
    do_stop();
    do_start();
    send(8'hB8);
    send(8'h20);
    exp_both("R7", 1'b1, 1'b0, 1'b0);
    send(8'h00);
    exp_both("R4", 1'b0, 1'b0, 1'b0);
    do_stop();
    do_start();
    send(8'hB8);
    send(8'h70);
    exp_both("R7", 1'b1, 1'b0, 1'b0);
    do_stop();
  endtask

  task automatic t_termination();
    do_start();
    send(8'hA8);
    send(8'h10);
    do_start();
    send(8'hB8);
    exp_both("R8", 1'b1, 1'b0, 1'b0);
    send(8'h00);
    exp_both("R4", 1'b0, 1'b0, 1'b0);
    do_start();
    send(8'hB8);
    exp_both("R8", 1'b1, 1'b0, 1'b0);
    do_stop();
    do_start();
    send(8'hB8);
    exp_both("R8", 1'b1, 1'b1, 1'b0);
    do_stop();
    do_start();
    send(8'hA9);
    exp_both("R6", 1'b1, 1'b1, 1'b1);
    do_mnack();
    do_start();
    send(8'hB9);
    exp_both("R8", 1'b1, 1'b1, 1'b1);
    ck("R8", "w9 region", a_rg, 2'd1);
    do_stop();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_array_write();
    t_bad_type();
    t_hw_match();
    t_current_read();
    t_restart_read();
    t_aux_decode();
    t_termination();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule